// File: doc/BRIEF.md
# Transmit Statistics Counter Block

This block keeps three statistics counters for the transmit side of an Ethernet MAC that can run in half or full duplex. One counts collisions. One counts frames that were held back before they could start. One counts frames that finished without the PHY ever showing carrier sense early in the frame. The transmit MAC drives per-cycle event strobes into the block, along with a per-bit-time enable. Software reads the counters through a registered read port at fixed offsets. Each read returns the value and clears that counter.

Two small state machines qualify the events. The carrier monitor has the states CS_IDLE, CS_WINDOW, CS_SEEN and CS_MISSED.
- CS_IDLE goes to CS_SEEN on a TX_EN rising edge when carrier is already present, and to CS_WINDOW on a rising edge without it.
- CS_WINDOW goes to CS_SEEN on carrier. It goes to CS_MISSED when the bit tick that completes the slot time arrives.
- Every tracking state returns to CS_IDLE on frame completion or when TX_EN falls.

The defer tracker has the states DS_READY and DS_HELD.
- DS_READY goes to DS_HELD, counting once, when a qualified defer cause appears while no frame is on the wire.
- DS_HELD returns to DS_READY when TX_EN rises.

All widths and the slot length are parameters. With the defaults, the counters are 32 bits wide and the slot is 512 bit times.

Top module: `tx_stat_counters`

## Requirements
- R1: After reset, all three counters read as zero.
- R2: A read is a rd_en strobe with rd_addr set to 16'h4028 (collisions), 16'h4030 (defers) or 16'h4034 (no-carrier frames). It places the counter value on rd_data on the clock edge that ends the strobe cycle. That value excludes any increment from the same cycle. A read of any other address returns zero and clears nothing.
- R3: A read clears the counter it selects. An increment in the same cycle as the read is kept, so the counter then holds 1.
- R4: The collision counter gains one for every cycle in which collision is high while tx_enable and half_duplex are both high. Otherwise it holds.
- R5: A defer cause is any of the following: medium busy, half-duplex deferral, XOFF pause, link down, or inter-packet gap. While tx_enable is high and tx_en is low, the appearance of any such cause adds exactly one defer. This holds however many causes are active and however long they last. No further defer is counted until tx_en has been high.
- R6: An inter-packet-gap cause with streaming high and no other cause active does not count as a defer.
- R7: No defer is counted while tx_enable is low.
- R8: Carrier is taken as present under either of two conditions. The first is that crs is high in the TX_EN rising cycle. The second is that crs is high in a later cycle reached before SLOT_BITS bit_tick pulses have been completed in the cycles after the rising cycle.
- R9: On tx_done, the no-carrier counter gains one if carrier was not present. This includes a frame that ends while the window is still open and crs is low. A frame whose tx_en falls without tx_done counts nothing.
- R10: The no-carrier counter changes only when tx_enable and half_duplex are both high in the tx_done cycle.
- R11: Every counter stops at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmitter enabled |
| half_duplex | input | 1 | Link runs half duplex |
| bit_tick | input | 1 | One pulse per bit time |
| tx_en | input | 1 | Transmit enable toward the PHY |
| crs | input | 1 | Carrier sense from the PHY |
| collision | input | 1 | Collision strobe |
| dfr_busy | input | 1 | Medium busy with another station |
| dfr_ipg | input | 1 | Inter-packet gap not yet expired |
| dfr_hdx | input | 1 | Half-duplex deferral |
| dfr_xoff | input | 1 | Held by a received XOFF pause |
| dfr_link_down | input | 1 | Link not up |
| streaming | input | 1 | Back-to-back transmit in progress |
| tx_done | input | 1 | Frame completed successfully |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read offset |
| rd_data | output | CNT_W | Value of the last read |

## Verification
The hardest cases to reach are the two edges of the carrier window. Carrier must arrive exactly in the cycle carrying the last bit tick of the slot, or exactly one cycle later. It must also be held for hundreds of cycles, with no other event disturbing the frame tracking. Directed frames with a bit tick every cycle place crs on each side of that edge. Random frames use sparse ticks, and the bench counts the ticks itself to tell when the window closes. Saturation is out of reach for a 32-bit counter, so a second instance with 4-bit counters receives the same stimulus. Its reads are compared with the wide expectation capped at all ones.

// File: rtl/tx_stat_pkg.sv
`timescale 1ns/1ps
package tx_stat_pkg;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] OFS_COL = 16'h4028;
    localparam logic [ADDR_W-1:0] OFS_DEF = 16'h4030;
    localparam logic [ADDR_W-1:0] OFS_NOC = 16'h4034;

    typedef enum logic [1:0] {CS_IDLE, CS_WINDOW, CS_SEEN, CS_MISSED} crs_state_t;
    typedef enum logic {DS_READY, DS_HELD} defer_state_t;
endpackage

// File: rtl/tx_stat_counter.sv
`timescale 1ns/1ps
module tx_stat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] base;
    logic [W-1:0] nxt;

    // clear first, then apply a coincident increment, stop at all ones
    always_comb begin
        base = clr ? '0 : count;
        nxt  = base;
        if (inc && base != ALL_ONES) nxt = base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == ALL_ONES && !clr) |=> count == ALL_ONES);

    // R3
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == {{(W-1){1'b0}}, $past(inc)});

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/tx_crs_monitor.sv
`timescale 1ns/1ps
module tx_crs_monitor
    import tx_stat_pkg::*;
#(
    parameter int SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tx_en,
    input  logic crs,
    input  logic bit_tick,
    input  logic tx_done,
    output logic inc
);
    localparam int SW = $clog2(SLOT_BITS);
    localparam logic [SW-1:0] LAST = SW'(SLOT_BITS - 1);

    crs_state_t state, nxt;
    logic [SW-1:0] slot_cnt;
    logic          tx_en_q;
    logic          rise;

    assign rise = tx_en && !tx_en_q;

    always_comb begin
        nxt = state;
        unique case (state)
            CS_IDLE:   if (rise) nxt = crs ? CS_SEEN : CS_WINDOW;
            CS_WINDOW: begin
                if (tx_done || !tx_en)              nxt = CS_IDLE;
                else if (crs)                       nxt = CS_SEEN;
                else if (bit_tick && slot_cnt == LAST) nxt = CS_MISSED;
            end
            CS_SEEN:   if (tx_done || !tx_en) nxt = CS_IDLE;
            CS_MISSED: if (tx_done || !tx_en) nxt = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CS_IDLE;
            slot_cnt <= '0;
            tx_en_q  <= 1'b0;
        end else begin
            state   <= nxt;
            tx_en_q <= tx_en;
            if (state != CS_WINDOW)  slot_cnt <= '0;
            else if (bit_tick)       slot_cnt <= slot_cnt + 1'b1;
        end
    end

    always_comb begin
        inc = 1'b0;
        unique case (state)
            CS_IDLE:   inc = 1'b0;
            CS_WINDOW: inc = tx_done && active && !crs;
            CS_SEEN:   inc = 1'b0;
            CS_MISSED: inc = tx_done && active;
        endcase
    end

    // R8
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_WINDOW && bit_tick && slot_cnt == LAST && !crs && tx_en && !tx_done)
        |=> state == CS_MISSED);

    // R9
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> state == CS_IDLE);
endmodule

// File: rtl/tx_defer_tracker.sv
`timescale 1ns/1ps
module tx_defer_tracker
    import tx_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic tx_en,
    input  logic dfr_busy,
    input  logic dfr_ipg,
    input  logic dfr_hdx,
    input  logic dfr_xoff,
    input  logic dfr_link_down,
    input  logic streaming,
    output logic inc
);
    defer_state_t state, nxt;
    logic cause;
    logic start_ok;

    // gap-only hold during streaming is not a defer
    assign cause    = dfr_busy || dfr_hdx || dfr_xoff || dfr_link_down
                   || (dfr_ipg && !streaming);
    assign start_ok = tx_enable && !tx_en && cause;

    always_comb begin
        nxt = state;
        unique case (state)
            DS_READY: if (start_ok) nxt = DS_HELD;
            DS_HELD:  if (tx_en)    nxt = DS_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DS_READY;
        else        state <= nxt;
    end

    always_comb begin
        inc = 1'b0;
        unique case (state)
            DS_READY: inc = start_ok;
            DS_HELD:  inc = 1'b0;
        endcase
    end

    // R5
    defer_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> !inc);

    // R6
    stream_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && !dfr_busy && !dfr_hdx && !dfr_xoff && !dfr_link_down) |-> !inc);

    // R7
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |-> !inc);
endmodule

// File: rtl/tx_stat_counters.sv
`timescale 1ns/1ps
module tx_stat_counters
    import tx_stat_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int SLOT_BITS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              half_duplex,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              crs,
    input  logic              collision,
    input  logic              dfr_busy,
    input  logic              dfr_ipg,
    input  logic              dfr_hdx,
    input  logic              dfr_xoff,
    input  logic              dfr_link_down,
    input  logic              streaming,
    input  logic              tx_done,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int NCNT = 3;

    logic             hdx_active;
    logic [NCNT-1:0]  inc;
    logic [NCNT-1:0]  clr;
    logic [CNT_W-1:0] cnt [NCNT];

    assign hdx_active = tx_enable && half_duplex;
    assign inc[0]     = collision && hdx_active;

    tx_defer_tracker u_defer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_enable     (tx_enable),
        .tx_en         (tx_en),
        .dfr_busy      (dfr_busy),
        .dfr_ipg       (dfr_ipg),
        .dfr_hdx       (dfr_hdx),
        .dfr_xoff      (dfr_xoff),
        .dfr_link_down (dfr_link_down),
        .streaming     (streaming),
        .inc           (inc[1])
    );

    tx_crs_monitor #(.SLOT_BITS(SLOT_BITS)) u_crs (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (hdx_active),
        .tx_en    (tx_en),
        .crs      (crs),
        .bit_tick (bit_tick),
        .tx_done  (tx_done),
        .inc      (inc[2])
    );

    assign clr[0] = rd_en && rd_addr == OFS_COL;
    assign clr[1] = rd_en && rd_addr == OFS_DEF;
    assign clr[2] = rd_en && rd_addr == OFS_NOC;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        tx_stat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .clr   (clr[g]),
            .count (cnt[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            unique case (1'b1)
                clr[0]:  rd_data <= cnt[0];
                clr[1]:  rd_data <= cnt[1];
                clr[2]:  rd_data <= cnt[2];
                default: rd_data <= '0;
            endcase
        end
    end

    // R4
    col_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdx_active && !clr[0]) |=> $stable(cnt[0]));

    // R10
    noc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdx_active && !clr[2]) |=> $stable(cnt[2]));

    // R2
    rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr[1] |=> rd_data == $past(cnt[1]));
endmodule

// File: tb/tb_tx_stat_counters.sv
`timescale 1ns/1ps
module tb_tx_stat_counters;
    localparam int SLOT = 512;
    localparam logic [15:0] A_COL = 16'h4028;
    localparam logic [15:0] A_DEF = 16'h4030;
    localparam logic [15:0] A_NOC = 16'h4034;
    localparam logic [15:0] A_BAD = 16'h402C;

    logic clk = 0, rst_n = 0;
    logic tx_enable = 1, half_duplex = 1, bit_tick = 0, tx_en = 0, crs = 0;
    logic collision = 0, dfr_busy = 0, dfr_ipg = 0, dfr_hdx = 0, dfr_xoff = 0;
    logic dfr_link_down = 0, streaming = 0, tx_done = 0, rd_en = 0;
    logic [15:0] rd_addr = 0;
    logic [31:0] rd_data;
    logic [3:0]  rd_data_n;

    int checks = 0, errors = 0;
    int unsigned ecnt [3];
    bit dheld = 0, noc_inc = 0, rand_rd = 0, want_rd = 0, done_flag = 0;
    logic [15:0] want_addr = 0;
    string want_tag = "";
    int tick_pct = 100;

    always #2.5 clk = ~clk;

    tx_stat_counters #(.CNT_W(32), .SLOT_BITS(SLOT)) dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .half_duplex(half_duplex),
        .bit_tick(bit_tick), .tx_en(tx_en), .crs(crs), .collision(collision),
        .dfr_busy(dfr_busy), .dfr_ipg(dfr_ipg), .dfr_hdx(dfr_hdx), .dfr_xoff(dfr_xoff),
        .dfr_link_down(dfr_link_down), .streaming(streaming), .tx_done(tx_done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    tx_stat_counters #(.CNT_W(4), .SLOT_BITS(SLOT)) dut_narrow (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .half_duplex(half_duplex),
        .bit_tick(bit_tick), .tx_en(tx_en), .crs(crs), .collision(collision),
        .dfr_busy(dfr_busy), .dfr_ipg(dfr_ipg), .dfr_hdx(dfr_hdx), .dfr_xoff(dfr_xoff),
        .dfr_link_down(dfr_link_down), .streaming(streaming), .tx_done(tx_done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_n));

    function automatic int unsigned cap15(int unsigned v);
        return (v > 15) ? 15 : v;
    endfunction

    function automatic int addr_idx(logic [15:0] a);
        if (a == A_COL) return 0;
        if (a == A_DEF) return 1;
        if (a == A_NOC) return 2;
        return 3;
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle();
        bit rd;
        logic [15:0] a;
        int idx;
        int unsigned exp_r;
        bit col_i, def_i, cause;
        string tag;
        rd = 0; a = 0; tag = want_tag;
        if (want_rd) begin
            rd = 1; a = want_addr;
        end else if (rand_rd && ($urandom % 8 == 0)) begin
            rd = 1;
            case ($urandom % 4)
                0: a = A_COL;
                1: a = A_DEF;
                2: a = A_NOC;
                default: a = A_BAD;
            endcase
        end
        rd_en = rd; rd_addr = a;
        idx = addr_idx(a);
        if (tag == "") tag = (idx == 0) ? "R4" : (idx == 1) ? "R5" : (idx == 2) ? "R8" : "R2";
        col_i = collision && tx_enable && half_duplex;
        cause = dfr_busy || dfr_hdx || dfr_xoff || dfr_link_down || (dfr_ipg && !streaming);
        def_i = 0;
        if (dheld) begin
            if (tx_en) dheld = 0;
        end else if (!tx_en && tx_enable && cause) begin
            def_i = 1; dheld = 1;
        end
        exp_r = 0;
        if (rd && idx < 3) begin
            exp_r = ecnt[idx];
            ecnt[idx] = 0;
        end
        ecnt[0] += col_i;
        ecnt[1] += def_i;
        ecnt[2] += noc_inc;
        @(posedge clk); #1;
        if (rd) begin
            check(tag, rd_data, exp_r);
            check({"R11 narrow ", tag}, rd_data_n, cap15(exp_r));
        end
        want_rd = 0; want_tag = "";
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic rd(logic [15:0] a, string tag);
        want_rd = 1; want_addr = a; want_tag = tag;
        cycle();
    endtask

    task automatic quiet();
        collision = 0; dfr_busy = 0; dfr_ipg = 0; dfr_hdx = 0; dfr_xoff = 0;
        dfr_link_down = 0; streaming = 0; tx_done = 0; crs = 0; tx_en = 0;
        noc_inc = 0; bit_tick = 0;
    endtask

    task automatic pulse_tx();
        quiet(); tx_en = 1; cycle(); tx_en = 0; cycle();
    endtask

    task automatic frame(int len, int d, bit abort, bit rnd_col);
        int prior = 0;
        bit seen = 0;
        for (int i = 0; i < len; i++) begin
            tx_en = 1;
            crs = (d >= 0 && i >= d);
            bit_tick = (($urandom % 100) < tick_pct);
            collision = rnd_col && ($urandom % 16 == 0);
            if (crs && prior < SLOT) seen = 1;
            tx_done = (i == len - 1) && !abort;
            noc_inc = tx_done && !seen && tx_enable && half_duplex;
            cycle();
            if (i >= 1 && bit_tick) prior++;
        end
        quiet();
        cycle();
    endtask

    task automatic idle_rand(int n);
        for (int i = 0; i < n; i++) begin
            dfr_busy = ($urandom % 6 == 0);
            dfr_ipg = ($urandom % 4 == 0);
            dfr_hdx = ($urandom % 8 == 0);
            dfr_xoff = ($urandom % 8 == 0);
            dfr_link_down = ($urandom % 10 == 0);
            streaming = ($urandom % 2 == 0);
            collision = ($urandom % 8 == 0);
            bit_tick = ($urandom % 2 == 0);
            cycle();
        end
        quiet();
    endtask

    initial begin
        #950000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 3; k++) ecnt[k] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(A_COL, "R1"); rd(A_DEF, "R1"); rd(A_NOC, "R1");

        // R4 and R11: 20 collisions in half duplex
        collision = 1;
        repeat (20) cycle();
        collision = 0;
        rd(A_COL, "R4");

        // R4: full duplex collisions ignored
        half_duplex = 0; collision = 1;
        repeat (5) cycle();
        collision = 0; half_duplex = 1;
        rd(A_COL, "R4");

        // R3: read coinciding with a collision
        collision = 1;
        repeat (3) cycle();
        rd(A_COL, "R3");
        collision = 0;
        rd(A_COL, "R3");

        // R2: unmapped address reads zero, clears nothing
        collision = 1;
        repeat (2) cycle();
        collision = 0;
        rd(A_BAD, "R2");
        rd(A_COL, "R2");

        // R5: each defer cause alone, held three cycles, counts once
        for (int c = 0; c < 5; c++) begin
            quiet();
            case (c)
                0: dfr_busy = 1;
                1: dfr_ipg = 1;
                2: dfr_hdx = 1;
                3: dfr_xoff = 1;
                default: dfr_link_down = 1;
            endcase
            repeat (3) cycle();
            pulse_tx();
        end
        // R5: all causes together count once
        dfr_busy = 1; dfr_ipg = 1; dfr_hdx = 1; dfr_xoff = 1; dfr_link_down = 1;
        repeat (4) cycle();
        quiet();
        rd(A_DEF, "R5");
        pulse_tx();

        // R6: streaming gap-only hold is not a defer
        dfr_ipg = 1; streaming = 1;
        repeat (10) cycle();
        quiet();
        rd(A_DEF, "R6");
        dfr_ipg = 1; streaming = 1; dfr_busy = 1;
        repeat (3) cycle();
        quiet();
        rd(A_DEF, "R6");
        pulse_tx();

        // R7: transmitter disabled
        tx_enable = 0; dfr_busy = 1; dfr_xoff = 1;
        repeat (3) cycle();
        quiet(); tx_enable = 1;
        rd(A_DEF, "R7");

        // R8: carrier window edges, one tick per cycle
        tick_pct = 100;
        frame(SLOT + 20, SLOT, 0, 0);
        rd(A_NOC, "R8");
        frame(SLOT + 20, SLOT + 1, 0, 0);
        rd(A_NOC, "R8");
        frame(SLOT + 20, 0, 0, 0);
        rd(A_NOC, "R8");

        // R9: short frame without carrier counts, aborted frame does not
        frame(20, -1, 0, 0);
        frame(600, -1, 1, 0);
        rd(A_NOC, "R9");

        // R10: full duplex and transmitter off
        half_duplex = 0;
        frame(600, -1, 0, 0);
        half_duplex = 1;
        rd(A_NOC, "R10");
        tx_enable = 0;
        frame(600, -1, 0, 0);
        tx_enable = 1;
        rd(A_NOC, "R10");

        // random mix
        rand_rd = 1;
        for (int n = 0; n < 40; n++) begin
            int len, d;
            idle_rand(5 + $urandom % 40);
            half_duplex = ($urandom % 4 != 0);
            tx_enable = ($urandom % 8 != 0);
            case ($urandom % 3)
                0: tick_pct = 100;
                1: tick_pct = 50;
                default: tick_pct = 25;
            endcase
            len = 10 + $urandom % 1300;
            d = ($urandom % 3 == 0) ? -1 : int'($urandom % len);
            frame(len, d, ($urandom % 8 == 0), 1);
        end
        rand_rd = 0;
        tx_enable = 1; half_duplex = 1;
        quiet();
        rd(A_COL, "R4"); rd(A_DEF, "R5"); rd(A_NOC, "R9");

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule